// File: doc/BRIEF.md
# Limited Range Pixel Clamp

This block limits each component of a three-channel pixel stream (12 bits per component) to a video-legal window. One register stage sits between input and output. A clamp enable and a 3-bit format code choose between pass-through, a fixed window derived from an 8-, 10- or 12-bit component depth, and a programmable window with its own floor and ceiling for each of red, green and blue.

The enable, the format code and the six bounds are not used live. They are captured only with the first valid pixel of a frame, which is marked by a start-of-frame flag. That pixel already uses the newly captured settings, and they stay in force until the next frame begins, so one frame is never clamped against two different windows. After reset the held settings are: enable off, format code 0, and programmable floor and ceiling of 0x010 and 0xFEF on the 12-bit scale.

The fixed-depth windows are 16..235 scaled to the chosen depth and then left-aligned in the 12-bit word. Scaling and colour-space conversion belong to other stages.

Top module: `pxclamp_limited`

## Requirements
- R1: While reset is asserted and in the cycle after it, out_valid is 0 and out_r, out_g and out_b are 0. After reset the held enable is off, so valid pixels that arrive before the first start-of-frame pass through unchanged.
- R2: out_valid equals in_valid delayed by one clock. When in_valid is 0, the output components keep their previous values.
- R3: When the held clamp enable is 0, each output component equals its input component one cycle later, whatever the format code.
- R4: With the clamp enabled, format code 0 and the unlisted codes 4, 5 and 6 pass data through unchanged.
- R5: With the clamp enabled, format codes 1 (8-bit), 2 (10-bit) and 3 (12-bit) limit every component to 0x100..0xEB0. A value below the floor becomes 0x100 and a value above the ceiling becomes 0xEB0.
- R6: With the clamp enabled, format code 7 limits red, green and blue each to its own floor and ceiling, taken from lo_r/hi_r, lo_g/hi_g and lo_b/hi_b.
- R7: The enable, the format code and the bounds are captured only when in_valid and in_sof are both 1, and that pixel uses the captured values. Changes to these inputs at any other time, including in_sof with in_valid 0, have no effect.
- R8: A component lying inside the active window, including a value equal to the floor or the ceiling, is output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame; captures the settings when in_valid is 1 |
| in_r | input | 12 | Red component in |
| in_g | input | 12 | Green component in |
| in_b | input | 12 | Blue component in |
| clamp_en | input | 1 | Clamp enable (captured at start of frame) |
| clamp_fmt | input | 3 | Format code: 0 none, 1/2/3 fixed 8/10/12-bit window, 7 programmable |
| lo_r | input | 12 | Programmable red floor |
| hi_r | input | 12 | Programmable red ceiling |
| lo_g | input | 12 | Programmable green floor |
| hi_g | input | 12 | Programmable green ceiling |
| lo_b | input | 12 | Programmable blue floor |
| hi_b | input | 12 | Programmable blue ceiling |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red component out |
| out_g | output | 12 | Green component out |
| out_b | output | 12 | Blue component out |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid delay, and the outputs holding their values on idle cycles;
- pass-through whenever the clamp is inactive;
- every clamped component staying inside its window, and in-window values passing unchanged;
- the held settings changing only on a valid start-of-frame pixel.

Other behaviour only the bench's scenarios can show: the exact window each format code selects (0x100/0xEB0 for the fixed depths, the per-channel bounds for code 7), a start-of-frame pixel using its own newly captured settings, settings changed mid-frame being ignored, and the state seen after reset.

// File: rtl/pxclamp_pkg.sv
package pxclamp_pkg;

  localparam int unsigned FMT_W = 3;

  localparam logic [FMT_W-1:0] FMT_NONE = 3'd0;
  localparam logic [FMT_W-1:0] FMT_D8   = 3'd1;
  localparam logic [FMT_W-1:0] FMT_D10  = 3'd2;
  localparam logic [FMT_W-1:0] FMT_D12  = 3'd3;
  localparam logic [FMT_W-1:0] FMT_PROG = 3'd7;

  // Video black and white codes at 8-bit depth.
  localparam int unsigned BLACK_8 = 16;
  localparam int unsigned WHITE_8 = 235;

  // Reset bounds of the programmable window on the 12-bit scale.
  localparam int unsigned PROG_LO_12 = 16;
  localparam int unsigned PROG_HI_12 = 4079;

  // True when the code selects any clamping window.
  function automatic logic fmt_clamps(input logic [FMT_W-1:0] code);
    case (code)
      FMT_D8, FMT_D10, FMT_D12, FMT_PROG: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  // Component depth implied by a fixed-depth code.
  function automatic int unsigned depth_of(input logic [FMT_W-1:0] code);
    case (code)
      FMT_D10: return 10;
      FMT_D12: return 12;
      default: return 8;
    endcase
  endfunction

  // Scale an 8-bit code to 'depth' bits, then left-align it in a 'w'-bit word.
  function automatic int unsigned scale_code(input int unsigned code8,
                                             input int unsigned depth,
                                             input int unsigned w);
    return (code8 << (depth - 8)) << (w - depth);
  endfunction

  // Clamp x into [lo, hi]; a value below the floor takes precedence.
  function automatic int unsigned clamp_val(input int unsigned x,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

endpackage

// File: rtl/pxclamp_cfg_hold.sv
module pxclamp_cfg_hold
  import pxclamp_pkg::*;
#(
  parameter int unsigned W      = 12,
  parameter int unsigned NCH    = 3,
  parameter int unsigned DEF_LO = 16,
  parameter int unsigned DEF_HI = 4079
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic                     en_i,
  input  logic [FMT_W-1:0]         fmt_i,
  input  logic [NCH-1:0][W-1:0]    lo_i,
  input  logic [NCH-1:0][W-1:0]    hi_i,
  output logic                     en_eff,
  output logic [FMT_W-1:0]         fmt_eff,
  output logic [NCH-1:0][W-1:0]    lo_eff,
  output logic [NCH-1:0][W-1:0]    hi_eff,
  output logic                     held_en,
  output logic [FMT_W-1:0]         held_fmt,
  output logic [NCH-1:0][W-1:0]    held_lo,
  output logic [NCH-1:0][W-1:0]    held_hi
);

  localparam logic [W-1:0] LO_RST = W'(DEF_LO);
  localparam logic [W-1:0] HI_RST = W'(DEF_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_en  <= 1'b0;
      held_fmt <= FMT_NONE;
      held_lo  <= {NCH{LO_RST}};
      held_hi  <= {NCH{HI_RST}};
    end else if (take) begin
      held_en  <= en_i;
      held_fmt <= fmt_i;
      held_lo  <= lo_i;
      held_hi  <= hi_i;
    end
  end

  // The frame's first pixel already uses the settings it brings.
  assign en_eff  = take ? en_i  : held_en;
  assign fmt_eff = take ? fmt_i : held_fmt;
  assign lo_eff  = take ? lo_i  : held_lo;
  assign hi_eff  = take ? hi_i  : held_hi;

endmodule

// File: rtl/pxclamp_limits.sv
module pxclamp_limits
  import pxclamp_pkg::*;
#(
  parameter int unsigned W   = 12,
  parameter int unsigned NCH = 3
) (
  input  logic                  en,
  input  logic [FMT_W-1:0]      fmt,
  input  logic [NCH-1:0][W-1:0] prog_lo,
  input  logic [NCH-1:0][W-1:0] prog_hi,
  output logic                  active,
  output logic [NCH-1:0][W-1:0] lim_lo,
  output logic [NCH-1:0][W-1:0] lim_hi
);

  logic is_prog;
  logic [W-1:0] fix_lo;
  logic [W-1:0] fix_hi;

  assign active  = en && fmt_clamps(fmt);
  assign is_prog = (fmt == FMT_PROG);
  assign fix_lo  = W'(scale_code(BLACK_8, depth_of(fmt), W));
  assign fix_hi  = W'(scale_code(WHITE_8, depth_of(fmt), W));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      if (!active) begin
        lim_lo[c] = '0;
        lim_hi[c] = '1;
      end else if (is_prog) begin
        lim_lo[c] = prog_lo[c];
        lim_hi[c] = prog_hi[c];
      end else begin
        lim_lo[c] = fix_lo;
        lim_hi[c] = fix_hi;
      end
    end
  end

endmodule

// File: rtl/pxclamp_lane.sv
module pxclamp_lane
  import pxclamp_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         active,
  input  logic [W-1:0] pix,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] res
);

  logic [W-1:0] bounded;

  assign bounded = W'(clamp_val(32'(pix), 32'(lo), 32'(hi)));
  assign res     = active ? bounded : pix;

endmodule

// File: rtl/pxclamp_limited.sv
module pxclamp_limited
  import pxclamp_pkg::*;
#(
  parameter int unsigned W   = 12,
  parameter int unsigned NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [W-1:0]     in_r,
  input  logic [W-1:0]     in_g,
  input  logic [W-1:0]     in_b,
  input  logic             clamp_en,
  input  logic [FMT_W-1:0] clamp_fmt,
  input  logic [W-1:0]     lo_r,
  input  logic [W-1:0]     hi_r,
  input  logic [W-1:0]     lo_g,
  input  logic [W-1:0]     hi_g,
  input  logic [W-1:0]     lo_b,
  input  logic [W-1:0]     hi_b,
  output logic             out_valid,
  output logic [W-1:0]     out_r,
  output logic [W-1:0]     out_g,
  output logic [W-1:0]     out_b
);

  // Programmable reset bounds are given on the 12-bit scale.
  localparam int unsigned DEF_LO = PROG_LO_12 << (W - 12);
  localparam int unsigned DEF_HI = PROG_HI_12 << (W - 12);

  // Channel 0 red, 1 green, 2 blue.
  logic [NCH-1:0][W-1:0] pix_in, bnd_lo, bnd_hi;
  logic [NCH-1:0][W-1:0] eff_lo, eff_hi, held_lo, held_hi;
  logic [NCH-1:0][W-1:0] lim_lo, lim_hi, pix_clamped, out_pix;
  logic                  take, eff_en, held_en, clamp_active;
  logic [FMT_W-1:0]      eff_fmt, held_fmt;

  assign pix_in = {in_b, in_g, in_r};
  assign bnd_lo = {lo_b, lo_g, lo_r};
  assign bnd_hi = {hi_b, hi_g, hi_r};
  assign take   = in_valid && in_sof;

  pxclamp_cfg_hold #(.W(W), .NCH(NCH), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_cfg (
    .clk(clk), .rst_n(rst_n), .take(take),
    .en_i(clamp_en), .fmt_i(clamp_fmt), .lo_i(bnd_lo), .hi_i(bnd_hi),
    .en_eff(eff_en), .fmt_eff(eff_fmt), .lo_eff(eff_lo), .hi_eff(eff_hi),
    .held_en(held_en), .held_fmt(held_fmt), .held_lo(held_lo), .held_hi(held_hi)
  );

  pxclamp_limits #(.W(W), .NCH(NCH)) u_lim (
    .en(eff_en), .fmt(eff_fmt), .prog_lo(eff_lo), .prog_hi(eff_hi),
    .active(clamp_active), .lim_lo(lim_lo), .lim_hi(lim_hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    pxclamp_lane #(.W(W)) u_lane (
      .active(clamp_active), .pix(pix_in[c]),
      .lo(lim_lo[c]), .hi(lim_hi[c]), .res(pix_clamped[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= pix_clamped;
    end
  end

  assign out_r = out_pix[0];
  assign out_g = out_pix[1];
  assign out_b = out_pix[2];

endmodule

// File: rtl/pxclamp_chk.sv
module pxclamp_chk
  import pxclamp_pkg::*;
#(
  parameter int unsigned W   = 12,
  parameter int unsigned NCH = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_sof,
  input logic                  out_valid,
  input logic                  clamp_active,
  input logic [NCH-1:0][W-1:0] pix_in,
  input logic [NCH-1:0][W-1:0] lim_lo,
  input logic [NCH-1:0][W-1:0] lim_hi,
  input logic [NCH-1:0][W-1:0] out_pix,
  input logic                  held_en,
  input logic [FMT_W-1:0]      held_fmt,
  input logic [NCH-1:0][W-1:0] held_lo,
  input logic [NCH-1:0][W-1:0] held_hi
);

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));

  // R3 R4
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !clamp_active |=> out_pix == $past(pix_in));

  // R7
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sof) |=> $stable(held_en) && $stable(held_fmt)
                              && $stable(held_lo) && $stable(held_hi));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R5 R6
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && clamp_active && (lim_lo[c] <= lim_hi[c])
      |=> (out_pix[c] >= $past(lim_lo[c])) && (out_pix[c] <= $past(lim_hi[c])));

    // R8
    keep_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && clamp_active && (pix_in[c] >= lim_lo[c]) && (pix_in[c] <= lim_hi[c])
      |=> out_pix[c] == $past(pix_in[c]));
  end

endmodule

bind pxclamp_limited pxclamp_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .clamp_active(clamp_active), .pix_in(pix_in),
  .lim_lo(lim_lo), .lim_hi(lim_hi), .out_pix(out_pix),
  .held_en(held_en), .held_fmt(held_fmt), .held_lo(held_lo), .held_hi(held_hi)
);

// File: tb/pxclamp_limited_test.sv
`timescale 1ns/1ps
module pxclamp_limited_test;

  localparam int W = 12;
  localparam logic [11:0] DL = 12'h010;
  localparam logic [11:0] DH = 12'hFEF;

  typedef struct packed {
    logic sof; logic en; logic [2:0] fmt;
    logic [11:0] r, g, b;
    logic [11:0] lr, lg, lb, hr, hg, hb;
    logic [11:0] er, eg, eb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3: enable off, code 1 ignored
    '{1'b1,1'b0,3'd1, 12'h000,12'h050,12'hFFF, DL,DL,DL,DH,DH,DH, 12'h000,12'h050,12'hFFF},
    // R4: code 0
    '{1'b1,1'b1,3'd0, 12'h000,12'hFFF,12'h800, DL,DL,DL,DH,DH,DH, 12'h000,12'hFFF,12'h800},
    // R4: unlisted code 5
    '{1'b1,1'b1,3'd5, 12'h001,12'hFFE,12'h0FF, DL,DL,DL,DH,DH,DH, 12'h001,12'hFFE,12'h0FF},
    // R5: 8-bit window
    '{1'b1,1'b1,3'd1, 12'h000,12'hFFF,12'h800, DL,DL,DL,DH,DH,DH, 12'h100,12'hEB0,12'h800},
    // R5 R8: 10-bit window, edges
    '{1'b1,1'b1,3'd2, 12'h0FF,12'hEB1,12'h100, DL,DL,DL,DH,DH,DH, 12'h100,12'hEB0,12'h100},
    // R5 R8: 12-bit window
    '{1'b1,1'b1,3'd3, 12'hEB0,12'h0AB,12'hF00, DL,DL,DL,DH,DH,DH, 12'hEB0,12'h100,12'hEB0},
    // R6: per-channel bounds
    '{1'b1,1'b1,3'd7, 12'h005,12'h250,12'hFFF, 12'h010,12'h200,12'h040,12'hFEF,12'h300,12'h0C0, 12'h010,12'h250,12'h0C0},
    // R7: mid-frame changes ignored, held code 7
    '{1'b0,1'b0,3'd0, 12'h000,12'h1FF,12'h0C1, 12'h000,12'h000,12'h000,12'hFFF,12'hFFF,12'hFFF, 12'h010,12'h200,12'h0C0},
    // R7
    '{1'b0,1'b1,3'd1, 12'hFFF,12'h301,12'h03F, DL,DL,DL,DH,DH,DH, 12'hFEF,12'h300,12'h040},
    // R6 R8: default bounds supplied, edges
    '{1'b1,1'b1,3'd7, 12'h010,12'hFEF,12'h00F, DL,DL,DL,DH,DH,DH, 12'h010,12'hFEF,12'h010},
    // R3: enable off with code 7
    '{1'b1,1'b0,3'd7, 12'hFFF,12'h000,12'h005, DL,DL,DL,DH,DH,DH, 12'hFFF,12'h000,12'h005},
    // R7: held disabled, mid-frame enable ignored
    '{1'b0,1'b1,3'd3, 12'hFFF,12'h000,12'h005, DL,DL,DL,DH,DH,DH, 12'hFFF,12'h000,12'h005}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, clamp_en = 1'b0;
  logic [2:0] clamp_fmt = 3'd0;
  logic [W-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic [W-1:0] lo_r = DL, lo_g = DL, lo_b = DL, hi_r = DH, hi_g = DH, hi_b = DH;
  logic out_valid;
  logic [W-1:0] out_r, out_g, out_b;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pxclamp_limited uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .clamp_en(clamp_en), .clamp_fmt(clamp_fmt),
    .lo_r(lo_r), .hi_r(hi_r), .lo_g(lo_g), .hi_g(hi_g), .lo_b(lo_b), .hi_b(hi_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic e, input logic [2:0] f,
                       input logic [11:0] r, input logic [11:0] g, input logic [11:0] b);
    in_valid = v; in_sof = s; clamp_en = e; clamp_fmt = f;
    in_r = r; in_g = g; in_b = b;
  endtask

  task automatic chk_px(input string tag, input logic [11:0] r, input logic [11:0] g,
                        input logic [11:0] b);
    chk({tag, " r"}, out_r, r);
    chk({tag, " g"}, out_g, g);
    chk({tag, " b"}, out_b, b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: state during reset
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 12'(out_valid), 12'h0);
    chk_px("R1 data in reset", 12'h0, 12'h0, 12'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 12'(out_valid), 12'h0);

    // R1: held enable off, no frame start yet
    drive(1'b1, 1'b0, 1'b1, 3'd1, 12'h000, 12'hFFF, 12'h800);
    @(negedge clk);
    chk("R1 valid", 12'(out_valid), 12'h1);
    chk_px("R1 pass before first frame", 12'h000, 12'hFFF, 12'h800);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].sof, VECS[i].en, VECS[i].fmt, VECS[i].r, VECS[i].g, VECS[i].b);
      lo_r = VECS[i].lr; lo_g = VECS[i].lg; lo_b = VECS[i].lb;
      hi_r = VECS[i].hr; hi_g = VECS[i].hg; hi_b = VECS[i].hb;
      @(negedge clk);
      chk($sformatf("R2 vec%0d valid", i), 12'(out_valid), 12'h1);
      chk_px($sformatf("vec%0d R3-R8 table", i), VECS[i].er, VECS[i].eg, VECS[i].eb);
    end
    lo_r = DL; lo_g = DL; lo_b = DL; hi_r = DH; hi_g = DH; hi_b = DH;

    // R2: idle cycle holds data; R7: sof without valid does not capture
    drive(1'b0, 1'b1, 1'b1, 3'd1, 12'h123, 12'h456, 12'h789);
    @(negedge clk);
    chk("R2 valid low", 12'(out_valid), 12'h0);
    chk_px("R2 idle hold", 12'hFFF, 12'h000, 12'h005);
    drive(1'b1, 1'b0, 1'b0, 3'd0, 12'h000, 12'hFFF, 12'h050);
    @(negedge clk);
    chk("R2 valid back", 12'(out_valid), 12'h1);
    chk_px("R7 sof without valid ignored", 12'h000, 12'hFFF, 12'h050);

    // R5 then reset mid-stream (R1)
    drive(1'b1, 1'b1, 1'b1, 3'd2, 12'hFFF, 12'h000, 12'h7FF);
    @(negedge clk);
    chk_px("R5 10-bit window", 12'hEB0, 12'h100, 12'h7FF);
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 3'd0, 12'h0, 12'h0, 12'h0);
    @(negedge clk);
    chk("R1 valid cleared", 12'(out_valid), 12'h0);
    chk_px("R1 data cleared", 12'h0, 12'h0, 12'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule